// File: doc/BRIEF.md
# Condition Code and Branch Decision Unit

This block keeps the two-bit condition code of a general-register processor and decides whether branches are taken. An arithmetic result is classified as zero, negative or positive, and a separate overflow flag overrides that classification. The code is updated only when the instruction that produced the result asks for it. Loads, stores and moves leave the code as it is. The processor can also write the code directly when it restores its status word.

A branch request carries a four-bit mask, with one bit for each possible code value. The most significant mask bit stands for code 0. The unit answers one cycle later with a taken flag. It also handles two other branch kinds:
- Branch-and-save: the link value is the address of the next instruction.
- Count-down branch: the counter is decremented and the branch is taken while the new count is non-zero.

The target address is computed elsewhere.

Top module: `cc_br_unit`

## Requirements
- R1: When `res_valid` is high, `spm_valid` is low and `res_ovf` is low, `cc` becomes 0 for a zero result, 1 for a result whose MSB is set (two's complement negative) and 2 for any other result, one cycle later.
- R2: When `res_valid` is high, `spm_valid` is low and `res_ovf` is high, `cc` becomes 3 whatever the value.
- R3: With `res_valid` and `spm_valid` both low (loads, stores, moves, branches), `cc` keeps its value.
- R4: When `spm_valid` is high, `cc` takes `spm_cc` one cycle later, and this wins over a simultaneous `res_valid`.
- R5: For `br_kind`=0 (conditional), `br_taken` one cycle after the request equals mask bit `br_mask[3-cc]`, where `cc` is the value held in the request cycle (before any same-cycle update). `br_done` is high in that cycle.
- R6: A conditional request with mask 4'b1111 is always taken, and one with mask 4'b0000 is never taken.
- R7: For `br_kind`=1 (branch-and-save), the request is taken and the mask is ignored. One cycle later `link_we` is high and `link_data` equals `br_next_addr`.
- R8: For `br_kind`=2 (count-down), the mask is ignored. One cycle later `cnt_we` is high, `cnt_data` = `br_count`-1 modulo 2^DATA_W, and `br_taken` is high exactly when that value is non-zero. The request does not alter `cc`.
- R9: `br_kind`=3 is reserved: `br_done` rises, `br_taken`, `link_we` and `cnt_we` stay low.
- R10: After reset, `cc` is 0 and every output is 0.
- R11: With `br_valid` low, the next cycle shows `br_done`, `br_taken`, `link_we` and `cnt_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Result should set the condition code |
| res_value | input | DATA_W | Arithmetic result |
| res_ovf | input | 1 | Result overflowed |
| spm_valid | input | 1 | Direct load of the condition code |
| spm_cc | input | 2 | Code value for the direct load |
| br_valid | input | 1 | Branch request |
| br_kind | input | 2 | 0 conditional, 1 branch-and-save, 2 count-down, 3 reserved |
| br_mask | input | 4 | Branch mask, bit 3 enables on code 0 |
| br_next_addr | input | ADDR_W | Address of the following instruction |
| br_count | input | DATA_W | Current counter register value |
| cc | output | 2 | Condition code |
| br_done | output | 1 | Branch decision valid |
| br_taken | output | 1 | Branch taken |
| link_we | output | 1 | Write link register |
| link_data | output | ADDR_W | Return address |
| cnt_we | output | 1 | Write counter register |
| cnt_data | output | DATA_W | Decremented count |

## Verification
The bench builds the unit with its defaults: DATA_W=32 and ADDR_W=31. The full 32-bit width matters for two edges of the classifier and the decrement. The value 32'h8000_0000 sits where the sign decision flips. A count of 0 wraps to all ones and must branch, while a count of 1 must not. Full-width link addresses also show that no upper address bit is lost.

// File: rtl/cc_br_pkg.sv
package cc_br_pkg;
  typedef enum logic [1:0] {
    BR_COND  = 2'd0,
    BR_SAVE  = 2'd1,
    BR_COUNT = 2'd2,
    BR_RSVD  = 2'd3
  } br_kind_e;

  localparam logic [1:0] CC_ZERO = 2'd0;
  localparam logic [1:0] CC_NEG  = 2'd1;
  localparam logic [1:0] CC_POS  = 2'd2;
  localparam logic [1:0] CC_OVF  = 2'd3;

  // mask MSB selects code 0, LSB selects code 3
  function automatic logic mask_hit(input logic [3:0] mask, input logic [1:0] code);
    return mask[2'd3 - code];
  endfunction
endpackage

// File: rtl/cc_classify.sv
module cc_classify #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  input  logic              ovf,
  output logic [1:0]        code
);
  import cc_br_pkg::*;

  function automatic logic [1:0] classify(input logic [DATA_W-1:0] v, input logic o);
    if (o)            return CC_OVF;
    if (v == '0)      return CC_ZERO;
    if (v[DATA_W-1])  return CC_NEG;
    return CC_POS;
  endfunction

  assign code = classify(value, ovf);
endmodule

// File: rtl/cc_state.sv
module cc_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       res_valid,
  input  logic [1:0] res_code,
  input  logic       spm_valid,
  input  logic [1:0] spm_code,
  output logic       cc_load,
  output logic [1:0] cc
);
  logic [1:0] cc_next;

  assign cc_load = res_valid | spm_valid;

  always_comb begin
    cc_next = cc;
    if (spm_valid)      cc_next = spm_code;
    else if (res_valid) cc_next = res_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cc <= 2'd0;
    else        cc <= cc_next;
  end
endmodule

// File: rtl/br_resolve.sv
module br_resolve #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [1:0]        br_kind,
  input  logic [3:0]        br_mask,
  input  logic [ADDR_W-1:0] br_next_addr,
  input  logic [DATA_W-1:0] br_count,
  input  logic [1:0]        cc,
  output logic              br_hit,
  output logic              br_done,
  output logic              br_taken,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_data,
  output logic              cnt_we,
  output logic [DATA_W-1:0] cnt_data
);
  import cc_br_pkg::*;

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  br_kind_e          kind;
  logic              link_d;
  logic              cnt_d;
  logic [DATA_W-1:0] cnt_dec;

  assign kind    = br_kind_e'(br_kind);
  assign cnt_dec = br_count - ONE;

  always_comb begin
    br_hit = 1'b0;
    link_d = 1'b0;
    cnt_d  = 1'b0;
    if (br_valid) begin
      unique case (kind)
        BR_COND:  br_hit = mask_hit(br_mask, cc);
        BR_SAVE:  begin br_hit = 1'b1; link_d = 1'b1; end
        BR_COUNT: begin br_hit = |cnt_dec; cnt_d = 1'b1; end
        BR_RSVD:  br_hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_done   <= 1'b0;
      br_taken  <= 1'b0;
      link_we   <= 1'b0;
      cnt_we    <= 1'b0;
      link_data <= '0;
      cnt_data  <= '0;
    end else begin
      br_done  <= br_valid;
      br_taken <= br_hit;
      link_we  <= link_d;
      cnt_we   <= cnt_d;
      if (link_d) link_data <= br_next_addr;
      if (cnt_d)  cnt_data  <= cnt_dec;
    end
  end
endmodule

// File: rtl/cc_br_unit.sv
module cc_br_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_value,
  input  logic              res_ovf,
  input  logic              spm_valid,
  input  logic [1:0]        spm_cc,
  input  logic              br_valid,
  input  logic [1:0]        br_kind,
  input  logic [3:0]        br_mask,
  input  logic [ADDR_W-1:0] br_next_addr,
  input  logic [DATA_W-1:0] br_count,
  output logic [1:0]        cc,
  output logic              br_done,
  output logic              br_taken,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_data,
  output logic              cnt_we,
  output logic [DATA_W-1:0] cnt_data
);
  logic [1:0] res_code;
  logic       cc_load;
  logic       br_hit;

  cc_classify #(.DATA_W(DATA_W)) classify_i (
    .value (res_value),
    .ovf   (res_ovf),
    .code  (res_code)
  );

  cc_state state_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_code  (res_code),
    .spm_valid (spm_valid),
    .spm_code  (spm_cc),
    .cc_load   (cc_load),
    .cc        (cc)
  );

  br_resolve #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) resolve_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_valid     (br_valid),
    .br_kind      (br_kind),
    .br_mask      (br_mask),
    .br_next_addr (br_next_addr),
    .br_count     (br_count),
    .cc           (cc),
    .br_hit       (br_hit),
    .br_done      (br_done),
    .br_taken     (br_taken),
    .link_we      (link_we),
    .link_data    (link_data),
    .cnt_we       (cnt_we),
    .cnt_data     (cnt_data)
  );
endmodule

// File: rtl/cc_br_unit_chk.sv
module cc_br_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_value,
  input logic              res_ovf,
  input logic              spm_valid,
  input logic [1:0]        spm_cc,
  input logic              br_valid,
  input logic [1:0]        br_kind,
  input logic [3:0]        br_mask,
  input logic [ADDR_W-1:0] br_next_addr,
  input logic [DATA_W-1:0] br_count,
  input logic [1:0]        cc,
  input logic              cc_load,
  input logic              br_hit,
  input logic              br_done,
  input logic              br_taken,
  input logic              link_we,
  input logic [ADDR_W-1:0] link_data,
  input logic              cnt_we,
  input logic [DATA_W-1:0] cnt_data
);
  AST_CC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !spm_valid && !res_ovf && res_value == '0) |=> cc == 2'd0); // R1
  AST_CC_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !spm_valid && !res_ovf && res_value[DATA_W-1]) |=> cc == 2'd1); // R1
  AST_CC_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !spm_valid && res_ovf) |=> cc == 2'd3); // R2
  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_load |=> $stable(cc)); // R3
  AST_SPM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    spm_valid |=> cc == $past(spm_cc)); // R4
  AST_HIT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    br_hit |=> br_taken && br_done); // R5
  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 2'd0 && br_mask == 4'hF) |=> br_taken); // R6
  AST_MASK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 2'd0 && br_mask == 4'h0) |=> !br_taken); // R6
  AST_LINK_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 2'd1) |=> link_we && br_taken && link_data == $past(br_next_addr)); // R7
  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 2'd2) |=> cnt_we && cnt_data == $past(br_count) - DATA_W'(1)); // R8
  AST_COUNT_CC: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 2'd2 && !res_valid && !spm_valid) |=> $stable(cc)); // R8
  AST_RSVD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 2'd3) |=> br_done && !br_taken && !link_we && !cnt_we); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !br_done && !br_taken && !link_we && !cnt_we); // R11
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({link_we, cnt_we})); // R7
endmodule

bind cc_br_unit cc_br_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
  .res_ovf(res_ovf), .spm_valid(spm_valid), .spm_cc(spm_cc),
  .br_valid(br_valid), .br_kind(br_kind), .br_mask(br_mask),
  .br_next_addr(br_next_addr), .br_count(br_count), .cc(cc),
  .cc_load(cc_load), .br_hit(br_hit), .br_done(br_done),
  .br_taken(br_taken), .link_we(link_we), .link_data(link_data),
  .cnt_we(cnt_we), .cnt_data(cnt_data)
);

// File: tb/cc_br_unit_tb_top.sv
module cc_br_unit_tb_top;
  localparam int DW = 32;
  localparam int AW = 31;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          res_valid = 1'b0;
  logic [DW-1:0] res_value = '0;
  logic          res_ovf = 1'b0;
  logic          spm_valid = 1'b0;
  logic [1:0]    spm_cc = '0;
  logic          br_valid = 1'b0;
  logic [1:0]    br_kind = '0;
  logic [3:0]    br_mask = '0;
  logic [AW-1:0] br_next_addr = '0;
  logic [DW-1:0] br_count = '0;
  logic [1:0]    cc;
  logic          br_done, br_taken, link_we, cnt_we;
  logic [AW-1:0] link_data;
  logic [DW-1:0] cnt_data;

  int unsigned vectors = 0;
  int unsigned miscompares = 0;
  logic [1:0]  m_cc = 2'd0;

  always #5 clk = ~clk;

  cc_br_unit #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
    .res_ovf(res_ovf), .spm_valid(spm_valid), .spm_cc(spm_cc),
    .br_valid(br_valid), .br_kind(br_kind), .br_mask(br_mask),
    .br_next_addr(br_next_addr), .br_count(br_count), .cc(cc),
    .br_done(br_done), .br_taken(br_taken), .link_we(link_we),
    .link_data(link_data), .cnt_we(cnt_we), .cnt_data(cnt_data)
  );

  function automatic logic [1:0] b_code(input logic [DW-1:0] v, input logic o);
    if (o) return 2'd3;
    if ($signed(v) < 0) return 2'd1;
    return (v == 0) ? 2'd0 : 2'd2;
  endfunction

  function automatic logic b_take(input logic [3:0] m, input logic [1:0] c);
    case (c)
      2'd0:    return m[3];
      2'd1:    return m[2];
      2'd2:    return m[1];
      default: return m[0];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic apply(input logic rv, input logic [DW-1:0] val, input logic ov,
                       input logic sv, input logic [1:0] sc,
                       input logic bv, input logic [1:0] bk, input logic [3:0] bm,
                       input logic [AW-1:0] na, input logic [DW-1:0] cnt);
    logic          e_tk, e_lw, e_cw;
    logic [DW-1:0] e_cd;
    string         cc_tag, br_tag;
    res_valid = rv; res_value = val; res_ovf = ov;
    spm_valid = sv; spm_cc = sc;
    br_valid = bv; br_kind = bk; br_mask = bm; br_next_addr = na; br_count = cnt;
    e_tk = 1'b0; e_lw = 1'b0; e_cw = 1'b0; e_cd = cnt + {DW{1'b1}};
    br_tag = "R11";
    if (bv) begin
      case (bk)
        2'd0: begin e_tk = b_take(bm, m_cc); br_tag = (bm == 4'hF || bm == 4'h0) ? "R6" : "R5"; end
        2'd1: begin e_tk = 1'b1; e_lw = 1'b1; br_tag = "R7"; end
        2'd2: begin e_cw = 1'b1; e_tk = (e_cd != 0); br_tag = "R8"; end
        default: br_tag = "R9";
      endcase
    end
    if (sv) begin m_cc = sc; cc_tag = "R4"; end
    else if (rv) begin m_cc = b_code(val, ov); cc_tag = ov ? "R2" : "R1"; end
    else cc_tag = (bv && bk == 2'd2) ? "R8" : "R3";
    @(negedge clk);
    chk(cc_tag, 64'(cc), 64'(m_cc));
    chk(br_tag, 64'(br_done), 64'(bv));
    chk(br_tag, 64'(br_taken), 64'(e_tk));
    chk(br_tag, 64'(link_we), 64'(e_lw));
    chk(br_tag, 64'(cnt_we), 64'(e_cw));
    if (e_lw) chk("R7", 64'(link_data), 64'(na));
    if (e_cw) chk("R8", 64'(cnt_data), 64'(e_cd));
  endtask

  task automatic idle();
    apply(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 4'h0, '0, '0);
  endtask

  initial begin
    #(500us);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", 64'(cc), 64'd0);
    chk("R10", 64'(br_done), 64'd0);
    chk("R10", 64'(br_taken), 64'd0);
    chk("R10", 64'(link_we), 64'd0);
    chk("R10", 64'(cnt_we), 64'd0);
    chk("R10", 64'(link_data), 64'd0);
    chk("R10", 64'(cnt_data), 64'd0);
    rst_n = 1'b1;
    idle();
    // R1 classification corners
    apply(1'b1, 32'h0000_0000, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 4'h0, '0, '0);
    apply(1'b1, 32'h8000_0000, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 4'h0, '0, '0);
    apply(1'b1, 32'h0000_0001, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 4'h0, '0, '0);
    apply(1'b1, 32'h7FFF_FFFF, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 4'h0, '0, '0);
    // R2 overflow beats zero
    apply(1'b1, 32'h0000_0000, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 4'h0, '0, '0);
    // R3 hold
    idle(); idle();
    // R4 direct load wins over a result
    apply(1'b1, 32'h0000_0000, 1'b0, 1'b1, 2'd2, 1'b0, 2'd0, 4'h0, '0, '0);
    // R5/R6 masks against each code, decided on the old code
    for (int c = 0; c < 4; c++) begin
      apply(1'b0, '0, 1'b0, 1'b1, 2'(c), 1'b0, 2'd0, 4'h0, '0, '0);
      apply(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0, 4'hF, '0, '0);
      apply(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0, 4'h0, '0, '0);
      apply(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0, 4'(8 >> c), '0, '0);
      apply(1'b1, '0, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 4'(4'hF ^ (8 >> c)), '0, '0);
    end
    // R7 branch-and-save with full-width address
    apply(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd1, 4'h0, {AW{1'b1}}, '0);
    apply(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd1, 4'hF, 31'h1234_5678, '0);
    // R8 count-down corners, with and without a result update
    apply(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd2, 4'hF, '0, 32'd1);
    apply(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd2, 4'h0, '0, 32'd0);
    apply(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 2'd0, 1'b1, 2'd2, 4'h0, '0, 32'd5);
    // R9 reserved kind
    apply(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd3, 4'hF, 31'h5, 32'd7);
    idle();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [DW-1:0] v, n;
      logic [3:0]    m;
      v = $urandom();
      if ($urandom_range(0, 4) == 0) v = '0;
      n = $urandom();
      if ($urandom_range(0, 3) == 0) n = DW'($urandom_range(0, 2));
      m = 4'($urandom());
      if ($urandom_range(0, 5) == 0) m = $urandom_range(0, 1) ? 4'hF : 4'h0;
      apply(1'($urandom()), v, ($urandom_range(0, 5) == 0),
            ($urandom_range(0, 7) == 0), 2'($urandom()),
            1'($urandom()), 2'($urandom()), m, AW'($urandom()), n);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule